// File: doc/BRIEF.md
# Programmable Feedback Divider

This block divides a feedback clock, normally taken from a voltage-controlled oscillator, by a ratio set by a parallel binary program word. It emits one single-cycle strobe for every N cycles of that clock, and the strobe goes to a phase comparator.

The program word is 9 bits wide by default, and its most significant bit is on the left. Most codes divide by their own binary value. The two lowest codes break that rule: code 0 divides by 2 and code 1 divides by 3, so the smallest ratio is never below 2.

A down counter loads the ratio minus one and counts to zero. On the edge where it reaches zero it reloads and raises the strobe. The program word is read only on that reload edge. A change to the word in the middle of a period therefore takes effect from the next period, and each period uses one consistent ratio.

Top module: `fb_divider`

## Requirements
- R1: While rst_ni is low, strobe_o is low. The first strobe appears in the cycle after the first rising clock edge following reset release.
- R2: Program code 0 gives a spacing of 2 clock cycles between consecutive strobes.
- R3: Program code 1 gives a spacing of 3 clock cycles between consecutive strobes.
- R4: Program codes 2 through 2^W-1 give a strobe spacing equal to the code value. The code is read as unsigned binary with bit W-1 as the most significant bit.
- R5: The program word is read only on the edge that raises the strobe. That value sets the length of the period that follows, and changes between reload edges do not alter that period.
- R6: strobe_o is high for exactly one clock cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Feedback clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_i | input | W (9) | Division program word, bit W-1 is the MSB |
| strobe_o | output | 1 | One-cycle strobe, once per divide period |

## Verification
The bench builds the block with the default 9-bit width, so the largest ratio of 511 can be reached along with the remapped codes 0 and 1. Directed runs cover codes 0, 1, 2, 3, 255 and 511. One run changes the code in the middle of a period to check that the new code applies only after the next reload. Random codes then run for many periods, and each spacing is compared with the ratio that was in force at the previous reload.

// File: rtl/fb_div_pkg.sv
package fb_div_pkg;
  typedef enum logic [1:0] {
    MAP_DIRECT = 2'd0,
    MAP_TWO    = 2'd1,
    MAP_THREE  = 2'd2
  } map_sel_e;
endpackage

// File: rtl/fb_ratio_map.sv
module fb_ratio_map #(
  parameter int W = 9
) (
  input  logic [W-1:0] prog_i,
  output logic [W-1:0] load_o
);
  import fb_div_pkg::*;

  map_sel_e sel;

  always_comb begin
    if (prog_i == '0)                  sel = MAP_TWO;
    else if (prog_i == W'(1))          sel = MAP_THREE;
    else                               sel = MAP_DIRECT;
  end

  // load value is ratio - 1
  always_comb begin
    unique case (sel)
      MAP_TWO:   load_o = W'(1);
      MAP_THREE: load_o = W'(2);
      default:   load_o = prog_i - W'(1);
    endcase
  end
endmodule

// File: rtl/fb_down_counter.sv
module fb_down_counter #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= load_i;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - W'(1);
      tick_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;

  assert_count_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
endmodule

// File: rtl/fb_divider.sv
module fb_divider #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] prog_i,
  output logic         strobe_o
);
  logic [W-1:0] load_val;
  logic [W-1:0] cnt;

  fb_ratio_map #(.W(W)) u_map (
    .prog_i (prog_i),
    .load_o (load_val)
  );

  fb_down_counter #(.W(W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_val),
    .cnt_o  (cnt),
    .tick_o (strobe_o)
  );

  // ratio never below 2, so a fresh load is never zero
  assert_min_ratio_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (cnt != '0));

  // spacing checker: cycles since last strobe stay within the largest ratio
  logic [W:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gap_q <= '0;
    else if (strobe_o) gap_q <= (W+1)'(1);
    else if (gap_q != '1) gap_q <= gap_q + (W+1)'(1);
  end

  assert_max_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q < (W+1)'(1 << W)));
endmodule

// File: tb/fb_divider_tb.sv
module fb_divider_tb;
  localparam int W = 9;
  localparam time CLK_PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] prog_i = '0;
  logic         strobe_o;

  int total = 0;
  int bad = 0;
  int gap = 0;
  int exp_gap = 0;
  bit have_prev = 1'b0;
  logic [W-1:0] cur_prog = '0;
  string cur_req = "R2";

  fb_divider #(.W(W)) u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prog_i   (prog_i),
    .strobe_o (strobe_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int ratio_of(logic [W-1:0] code);
    if (code == 0) return 2;
    if (code == 1) return 3;
    return int'(code);
  endfunction

  function automatic string req_of(logic [W-1:0] code);
    if (code == 0) return "R2";
    if (code == 1) return "R3";
    return "R4";
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one negedge step: observe, then optionally drive a new code
  task automatic step(bit change, logic [W-1:0] code);
    @(negedge clk_i);
    gap++;
    if (strobe_o) begin
      if (have_prev) check(cur_req, gap, exp_gap);
      have_prev = 1'b1;
      exp_gap = ratio_of(cur_prog);
      cur_req = req_of(cur_prog);
      gap = 0;
    end
    if (change) begin
      cur_prog = code;
      prog_i = code;
    end
  endtask

  // run a code for n periods, code applied right after a strobe
  task automatic run_code(logic [W-1:0] code, int periods);
    int seen = 0;
    while (!strobe_o) step(1'b0, '0);
    cur_prog = code;
    prog_i = code;
    while (seen < periods + 1) begin
      step(1'b0, '0);
      if (strobe_o) seen++;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    prog_i = 9'd5;
    cur_prog = 9'd5;
    repeat (3) @(negedge clk_i);
    check("R1", int'(strobe_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", int'(strobe_o), 1);
    have_prev = 1'b1;
    exp_gap = 5;
    cur_req = "R4";
    gap = 0;
    @(negedge clk_i);
    check("R6", int'(strobe_o), 0);
    gap = 1;

    run_code(9'd0, 4);
    run_code(9'd1, 4);
    run_code(9'd2, 3);
    run_code(9'd3, 3);
    run_code(9'd255, 2);
    run_code(9'd511, 2);

    // R5: change code mid-period, current period keeps old ratio
    run_code(9'd20, 1);
    repeat (7) step(1'b0, '0);
    step(1'b1, 9'd9);
    cur_req = "R5";
    begin
      int seen = 0;
      while (seen < 3) begin
        step(1'b0, '0);
        if (strobe_o) seen++;
      end
    end

    for (int i = 0; i < 120; i++) begin
      logic [W-1:0] code = W'($urandom_range(0, 511));
      if (i % 10 == 0) code = W'($urandom_range(0, 3));
      run_code(code, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule